// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter Bank

This block decides, for every identifier word taken off the CAN bus, whether the frame belongs in the receive FIFO. It holds four filters. Each filter has an enable bit, a 32-bit mask word and a 32-bit reference identifier. A received identifier matches a filter when the identifier and the reference agree on every bit the mask marks as significant. The frame is kept if any enabled filter matches. When no filter is enabled, the bank lets every frame through.

Software programs the bank through a single-cycle register port. Enable bits are changed through separate set and clear addresses, so changing one filter never disturbs another. A filter's mask and reference can be rewritten only while that filter is disabled and no comparison is in flight. The bank refuses any other write to them and records the refusal in a sticky flag that clears when software reads it. Identifiers arrive with a one-cycle strobe. The verdict appears two cycles later, together with the index of the lowest-numbered filter that matched.

Top module: `can_id_filter_bank`

## Requirements
- R1: After reset, all enable bits, masks, reference identifiers and the error flag are zero, and `busy` and `res_valid` are low.
- R2: Register map: address 0 reads the enable bits in [3:0] and zero in [31:4]. A write to address 1 sets the enable bits given by ones in wdata[3:0]. A write to address 2 clears those bits. All other enable bits keep their value.
- R3: Filter k (k = 0..3) matches identifier X when (X & mask_k) == (ref_k & mask_k). Mask k is at address 4+2k and reference k is at address 5+2k, both readable at the same addresses.
- R4: The frame is accepted (`res_accept`=1, `res_hit`=1) when at least one enabled filter matches. `res_idx` gives the lowest-numbered enabled matching filter. A disabled filter never matches. If some filters are enabled and none matches, `res_accept`=0 and `res_hit`=0.
- R5: With no filter enabled, every identifier is accepted with `res_hit`=0 and `res_idx`=0.
- R6: An `id_valid` strobe at a clock edge raises `busy` for exactly the next cycle. The result is held with `res_valid` high for the cycle after that. `busy` and `res_valid` are low when no identifier is in flight.
- R7: A write to a filter's mask or reference while that filter's enable bit is set leaves the stored value unchanged.
- R8: A write to any mask or reference while `busy` is high leaves the stored value unchanged.
- R9: A refused write (R7, R8) sets a sticky error flag, read as bit 0 of address 3. A read of address 3 returns the flag and clears it, unless a refusal occurs in the same cycle.
- R10: Read data appears on `reg_rdata` one cycle after the `reg_rd` strobe. It holds until the next read. Addresses 12..15 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after `reg_rd` |
| id_valid | input | 1 | Identifier strobe |
| id_word | input | 32 | Received identifier word |
| busy | output | 1 | Comparison in progress; filter writes refused |
| res_valid | output | 1 | Verdict valid |
| res_accept | output | 1 | Frame is to be stored |
| res_hit | output | 1 | An enabled filter matched |
| res_idx | output | 2 | Lowest matching filter index |

## Verification
The bound checker watches every cycle for the following:
- the exact spacing from strobe to `busy` to `res_valid`;
- the pass-all verdict whenever the enables were zero during a comparison;
- that a reported hit always names an enabled filter;
- that every refused filter write raises the error flag;
- the zero upper bits of the enable and flag reads.

Other behaviour only shows up in the bench's scenarios:
- the masked-equality rule itself;
- the lowest-index choice among several matching filters;
- that a refused write really leaves the stored word intact;
- the clear-on-read flag sequence.

// File: rtl/can_id_filter_bank.sv
module can_id_filter_bank #(
  parameter int N_FILT = 4,
  parameter int ID_W   = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [ID_W-1:0]   reg_wdata,
  output logic [ID_W-1:0]   reg_rdata,
  input  logic              id_valid,
  input  logic [ID_W-1:0]   id_word,
  output logic              busy,
  output logic              res_valid,
  output logic              res_accept,
  output logic              res_hit,
  output logic [((N_FILT > 1) ? $clog2(N_FILT) : 1)-1:0] res_idx
);
  localparam int IDX_W = (N_FILT > 1) ? $clog2(N_FILT) : 1;
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_ERR = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_FLT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_END = ADDR_W'(4 + 2 * N_FILT);

  logic [N_FILT-1:0] en_q;
  logic [ID_W-1:0]   mask_q [N_FILT];
  logic [ID_W-1:0]   ref_q  [N_FILT];
  logic [ID_W-1:0]   id_q;
  logic              cmp_v;
  logic              err_q;
  logic [N_FILT-1:0] hit;
  logic [IDX_W-1:0]  pidx;

  wire              in_flt = (reg_addr >= A_FLT) && (reg_addr < A_END);
  wire [IDX_W-1:0]  fsel   = IDX_W'((reg_addr - A_FLT) >> 1);
  wire              is_ref = reg_addr[0];
  wire              refuse = reg_wr && in_flt && (cmp_v || en_q[fsel]);
  wire              take   = reg_wr && in_flt && !refuse;

  assign busy = cmp_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      err_q <= 1'b0;
      cmp_v <= 1'b0;
      id_q  <= '0;
    end else begin
      if (reg_wr && reg_addr == A_SET) en_q <= en_q | reg_wdata[N_FILT-1:0];
      else if (reg_wr && reg_addr == A_CLR) en_q <= en_q & ~reg_wdata[N_FILT-1:0];
      if (refuse) err_q <= 1'b1;
      else if (reg_rd && reg_addr == A_ERR) err_q <= 1'b0;
      cmp_v <= id_valid;
      if (id_valid) id_q <= id_word;
    end
  end

  for (genvar k = 0; k < N_FILT; k++) begin : g_flt
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q[k] <= '0;
        ref_q[k]  <= '0;
      end else if (take && fsel == IDX_W'(k)) begin
        if (is_ref) ref_q[k]  <= reg_wdata;
        else        mask_q[k] <= reg_wdata;
      end
    end
    assign hit[k] = en_q[k] && (((id_q ^ ref_q[k]) & mask_q[k]) == '0);
  end

  always_comb begin
    pidx = '0;
    for (int k = N_FILT - 1; k >= 0; k--)
      if (hit[k]) pidx = IDX_W'(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_hit    <= 1'b0;
      res_idx    <= '0;
      reg_rdata  <= '0;
    end else begin
      res_valid <= cmp_v;
      if (cmp_v) begin
        res_accept <= (en_q == '0) || (|hit);
        res_hit    <= |hit;
        res_idx    <= pidx;
      end
      if (reg_rd) begin
        reg_rdata <= '0;
        if (reg_addr == A_EN)       reg_rdata[N_FILT-1:0] <= en_q;
        else if (reg_addr == A_ERR) reg_rdata[0] <= err_q;
        else if (in_flt)            reg_rdata <= is_ref ? ref_q[fsel] : mask_q[fsel];
      end
    end
  end
endmodule

// File: rtl/can_id_filter_bank_sva.sv
module can_id_filter_bank_sva #(
  parameter int N_FILT = 4,
  parameter int ID_W   = 32,
  parameter int ADDR_W = 4,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [ID_W-1:0]   reg_rdata,
  input logic              id_valid,
  input logic              busy,
  input logic              res_valid,
  input logic              res_accept,
  input logic              res_hit,
  input logic [IDX_W-1:0]  res_idx,
  input logic [N_FILT-1:0] en_q,
  input logic              err_q
);
  wire             flt_wr = reg_wr && (reg_addr >= ADDR_W'(4)) && (reg_addr < ADDR_W'(4 + 2 * N_FILT));
  wire [IDX_W-1:0] wsel   = IDX_W'((reg_addr - ADDR_W'(4)) >> 1);

  p_busy_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> busy);
  p_idle_not_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |=> !busy);
  p_result_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> res_valid);
  p_no_stray_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !res_valid);
  p_pass_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && en_q == '0) |=> (res_accept && !res_hit && res_idx == '0));
  p_hit_is_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && en_q != '0) |=> (!res_hit || (((en_q >> res_idx) & N_FILT'(1)) != '0) || !res_valid));
  p_hit_means_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> res_accept);
  p_refusal_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_wr && (busy || en_q[wsel])) |=> err_q);
  p_enable_read_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_W'(0)) |=> (reg_rdata >> N_FILT) == '0);
  p_flag_read_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_W'(3) && err_q) |=> reg_rdata == ID_W'(1));
endmodule

bind can_id_filter_bank can_id_filter_bank_sva #(
  .N_FILT(N_FILT), .ID_W(ID_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .id_valid(id_valid),
  .busy(busy), .res_valid(res_valid), .res_accept(res_accept),
  .res_hit(res_hit), .res_idx(res_idx), .en_q(en_q), .err_q(err_q)
);

// File: tb/can_id_filter_bank_test.sv
module can_id_filter_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        id_valid = 1'b0;
  logic [31:0] id_word = '0;
  logic        busy, res_valid, res_accept, res_hit;
  logic [1:0]  res_idx;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [3:0]  m_en = '0;
  logic [31:0] m_mask [4];
  logic [31:0] m_ref  [4];
  logic        m_err = 1'b0;

  always #10 clk = ~clk;

  can_id_filter_bank uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .id_valid(id_valid), .id_word(id_word), .busy(busy),
    .res_valid(res_valid), .res_accept(res_accept), .res_hit(res_hit),
    .res_idx(res_idx)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] expect_res(logic [31:0] id);
    logic [3:0] r;
    r = 4'b0000;
    if (m_en == 4'b0) return 4'b1000;
    for (int k = 3; k >= 0; k--)
      if (m_en[k] && ((id & m_mask[k]) == (m_ref[k] & m_mask[k])))
        r = {2'b11, 2'(k)};
    return r;
  endfunction

  task automatic model_wr(logic [3:0] a, logic [31:0] d, bit bsy);
    if (a == 4'd1) m_en = m_en | d[3:0];
    else if (a == 4'd2) m_en = m_en & ~d[3:0];
    else if (a >= 4'd4 && a < 4'd12) begin
      int k = (int'(a) - 4) >> 1;
      if (bsy || m_en[k]) m_err = 1'b1;
      else if (a[0]) m_ref[k] = d;
      else m_mask[k] = d;
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    model_wr(a, d, 1'b0);
  endtask

  task automatic rd_chk(string req, logic [3:0] a);
    logic [31:0] e;
    if (a == 4'd0) e = {28'b0, m_en};
    else if (a == 4'd3) e = {31'b0, m_err};
    else if (a >= 4'd4 && a < 4'd12) e = a[0] ? m_ref[(int'(a) - 4) >> 1] : m_mask[(int'(a) - 4) >> 1];
    else e = '0;
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    if (a == 4'd3) m_err = 1'b0;
    chk(req, reg_rdata, e);
  endtask

  task automatic send(string req, logic [31:0] id);
    logic [3:0] e;
    e = expect_res(id);
    @(negedge clk);
    id_valid = 1'b1; id_word = id;
    @(negedge clk);
    id_valid = 1'b0;
    chk("R6 busy", {31'b0, busy}, 32'd1);
    @(negedge clk);
    chk("R6 res_valid", {31'b0, res_valid}, 32'd1);
    chk("R6 busy low", {31'b0, busy}, 32'd0);
    chk(req, {28'b0, res_accept, res_hit, res_idx}, {28'b0, e});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int k = 0; k < 4; k++) begin m_mask[k] = '0; m_ref[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 res_valid", {31'b0, res_valid}, 32'd0);
    rd_chk("R1 enables", 4'd0);
    rd_chk("R1 flag", 4'd3);
    rd_chk("R1 mask2", 4'd8);
    rd_chk("R10 unused address", 4'd14);
    // R5 pass-all
    send("R5 pass all", 32'h1234_5678);
    send("R5 pass all", 32'hFFFF_FFFF);
    // R2 set/clear
    wr(4'd1, 32'h5);  wr(4'd1, 32'h2);
    rd_chk("R2 set merge", 4'd0);
    wr(4'd2, 32'h1);
    rd_chk("R2 clear one", 4'd0);
    wr(4'd1, 32'hFFFF_FFF0);
    rd_chk("R2 upper ignored", 4'd0);
    // R7 refused while enabled, R9 sticky clear-on-read
    wr(4'd6, 32'hDEAD_BEEF);
    rd_chk("R7 mask1 kept", 4'd6);
    rd_chk("R9 flag set", 4'd3);
    rd_chk("R9 flag cleared", 4'd3);
    // R3/R4 directed: filters 1 and 3 both match, lowest wins
    wr(4'd2, 32'hF);
    wr(4'd6, 32'h0000_FF00); wr(4'd7, 32'h0000_AB00);
    wr(4'd10, 32'h0000_0F00); wr(4'd11, 32'h0000_0B00);
    wr(4'd1, 32'hA);
    send("R4 lowest index", 32'h1234_AB77);
    send("R3 mask only filter3", 32'h0000_CB00);
    send("R4 no match rejects", 32'h0000_0000);
    wr(4'd2, 32'h2);
    send("R4 disabled filter ignored", 32'h0000_AB00);
    // R8 write refused while busy
    wr(4'd2, 32'hF);
    @(negedge clk);
    id_valid = 1'b1; id_word = 32'h0;
    @(negedge clk);
    id_valid = 1'b0;
    reg_wr = 1'b1; reg_addr = 4'd4; reg_wdata = 32'h0BAD_F00D;
    model_wr(4'd4, 32'h0BAD_F00D, 1'b1);
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R8 result", {28'b0, res_valid, res_accept, res_hit, 1'b0}, 32'hC);
    rd_chk("R8 mask0 kept", 4'd4);
    rd_chk("R9 flag after busy", 4'd3);
    // random
    for (int it = 0; it < 40; it++) begin
      int k = $urandom % 4;
      wr(4'd2, 32'hF);
      wr(4'(4 + 2 * k), $urandom | $urandom);
      wr(4'(5 + 2 * k), $urandom);
      wr(4'd1, {28'b0, 4'($urandom)});
      if ((it % 5) == 0) begin
        wr(4'(4 + 2 * ($urandom % 4)), $urandom);
        rd_chk("R9 random flag", 4'd3);
      end
      rd_chk("R3 random readback", 4'(4 + 2 * k));
      for (int j = 0; j < 3; j++) begin
        int f = $urandom % 4;
        logic [31:0] id;
        if (j != 2) id = (m_ref[f] & m_mask[f]) | ($urandom & ~m_mask[f]);
        else id = $urandom;
        send("R4 random verdict", id);
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule